// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog built from two countdown stages in cascade. Software writes each stage's preload value over a small register bus, then keeps the timer alive by writing a restart command. The preload registers and the restart register are guarded by a two-write unlock key, so stray stores cannot silently re-arm or retune the timer. When the first stage runs out it raises an interrupt, and the second stage starts counting. If the second stage also runs out, a sticky timeout flag is set and, when enabled, a reset request is raised toward the system reset generator.

A prescaler turns the bus clock into the decrement tick. It has a slow rate and a fast rate, chosen by a configuration bit. A control register enables the timer, selects watchdog or periodic-timer function, and has a lock bit. Once the lock bit is set, that register is frozen until the next block reset. The sticky flag has its own power-on reset, so it still reads back after the reset that the block itself requested.

Top module: `wdt2_top`

## Requirements
- R1: A write to a protected offset (stage-1 preload 0x00, stage-2 preload 0x04, restart 0x0C) changes state only when the two bus accesses just before it were writes of 0x00000080 and then 0x00000086 to offset 0x0C. Any other protected write is ignored.
- R2: One unlock grants exactly one access. Any bus access, read or write, that breaks the key pair, or that follows an unlock, re-arms the key check. A write of 0x80 to 0x0C, made while no grant is open, starts a new pair.
- R3: An unlocked write with bit 8 set to 0x0C restarts stage 1 from the stage-1 preload and clears the prescaler. Offset 0x18 reads the live count in bits 19:0, bit 24 = stage 2 active, bit 25 = expired and stopped.
- R4: While enabled, each stage lasts its preload in ticks (0 counts as 1). A tick comes every 2^FAST_SHIFT clocks when config bit 2 is 1, and every 2^SLOW_SHIFT clocks when it is 0. On stage-1 expiry, stage 2 loads its preload and status bit 0 (offset 0x08) is set.
- R5: Config bits 1:0 select the interrupt: 00 = `irq` follows status bit 0, which is cleared by writing 1 to it; 01 = a one-cycle `irq` pulse per stage-1 expiry; 10 and 11 = `irq` stays low.
- R6: On stage-2 expiry in watchdog function, bit 9 of offset 0x0C reads 1 and counting stops. `rst_req` rises only if config bit 5 is 1, and then stays high until a restart or `rst_n`.
- R7: The timeout flag is not cleared by `rst_n`. Only `por_n` or an unlocked write with bit 9 set to 0x0C clears it.
- R8: Control register 0x14 holds bit 0 = lock, bit 1 = enable, bit 2 = periodic function. With enable at 0, the count holds and the prescaler stays cleared.
- R9: While lock is 1, writes to 0x14 are ignored until `rst_n`.
- R10: With periodic function selected, stage-2 expiry restarts stage 1 from its preload. It sets no flag and raises no reset request.
- R11: After `rst_n`, both preloads and the count equal DEFAULT_PRELOAD in stage 1, config and control read 0, and `irq` and `rst_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| por_n | input | 1 | Synchronous active-low power-on reset for the timeout flag |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | 1 | Stage-1 interrupt |
| rst_req | output | 1 | Reset request on stage-2 expiry |

## Verification
A wrong state in the unlock sequencer shows at the next readback: a preload or count at the register bus that differs from the value written, or an unchanged value after a granted write. A prescaler or stage counter that is off by a tick moves the rise of `irq` or `rst_req` by a whole tick period. The bench checks these edges at the exact cycle, counted from the restart write. Errors in the lock and flag state show as readback values that are wrong across `rst_n`, and those checks are made right after the reset is released.

// File: rtl/wdt2_pkg.sv
// Package: shared offsets, key values, bit positions and types of the
// two-stage watchdog. Assumes byte offsets on a word-wide register bus.
package wdt2_pkg;

    // Register byte offsets
    localparam int unsigned OFS_PRE1   = 'h00;
    localparam int unsigned OFS_PRE2   = 'h04;
    localparam int unsigned OFS_STAT   = 'h08;
    localparam int unsigned OFS_RELOAD = 'h0C;
    localparam int unsigned OFS_CFG    = 'h10;
    localparam int unsigned OFS_CTRL   = 'h14;
    localparam int unsigned OFS_COUNT  = 'h18;

    // Unlock key pair, written in this order to OFS_RELOAD
    localparam int unsigned KEY_FIRST  = 'h80;
    localparam int unsigned KEY_SECOND = 'h86;

    // Restart register bits
    localparam int unsigned RLD_RESTART_BIT = 8;
    localparam int unsigned RLD_FLAG_BIT    = 9;

    // Configuration register bits
    localparam int unsigned CFG_RSTEN_BIT = 5;
    localparam int unsigned CFG_FAST_BIT  = 2;

    // Count readback status bits
    localparam int unsigned CNT_SECOND_BIT = 24;
    localparam int unsigned CNT_DONE_BIT   = 25;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_HALF = 2'd1,
        UL_OPEN = 2'd2
    } unlock_state_t;

    typedef enum logic [1:0] {
        ST_FIRST  = 2'd0,
        ST_SECOND = 2'd1,
        ST_DONE   = 2'd2
    } stage_t;

    typedef enum logic [1:0] {
        IRQ_LEVEL = 2'b00,
        IRQ_PULSE = 2'b01,
        IRQ_NONEA = 2'b10,
        IRQ_NONE  = 2'b11
    } irq_mode_t;

    // Configuration fields as stored
    typedef struct packed {
        logic      rst_en;
        logic      fast;
        irq_mode_t irq_mode;
    } wdt_cfg_t;

    // Control fields; packed order matches bits 2:0 of the register
    typedef struct packed {
        logic periodic;
        logic enable;
        logic locked;
    } wdt_ctrl_t;

endpackage

// File: rtl/wdt2_unlock.sv
// Unlock sequencer: watches bus accesses for the two-write key pair on the
// restart offset and opens a grant for exactly one following access.
// Assumes at most one bus access per cycle; synchronous active-low reset.
module wdt2_unlock
    import wdt2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc,        // a bus access happens this cycle
    input  logic wr,         // that access is a write
    input  logic at_reload,  // addressed to the restart offset
    input  logic key1_hit,   // write data equals first key
    input  logic key2_hit,   // write data equals second key
    output logic granted     // the current access is the granted one
);

    unlock_state_t state_q;
    unlock_state_t state_d;

    // Next state: a key write moves forward, any other access re-arms.
    always_comb begin
        state_d = state_q;
        if (acc) begin
            if (wr && at_reload && key1_hit && (state_q != UL_OPEN)) begin
                state_d = UL_HALF;
            end else if ((state_q == UL_HALF) && wr && at_reload && key2_hit) begin
                state_d = UL_OPEN;
            end else begin
                state_d = UL_IDLE;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // The grant covers whatever access comes while open.
    assign granted = (state_q == UL_OPEN);

endmodule

// File: rtl/wdt2_prescaler.sv
// Prescaler: divides clk into a one-cycle tick, every 2^FAST_SHIFT or
// 2^SLOW_SHIFT clocks. Held cleared while not running or on restart.
// Assumes FAST_SHIFT <= SLOW_SHIFT; synchronous active-low reset.
module wdt2_prescaler #(
    parameter int unsigned SLOW_SHIFT = 15,
    parameter int unsigned FAST_SHIFT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic fast,
    output logic tick
);

    localparam int unsigned PW = SLOW_SHIFT;
    localparam logic [PW-1:0] SLOW_LIM = {PW{1'b1}};
    localparam logic [PW-1:0] FAST_LIM = PW'((64'd1 << FAST_SHIFT) - 64'd1);

    logic [PW-1:0] div_q;
    logic [PW-1:0] limit;

    // Pick the terminal value for the selected rate.
    always_comb begin
        limit = fast ? FAST_LIM : SLOW_LIM;
    end

    // Terminal reached: >= also covers a switch from slow to fast.
    assign tick = run && (div_q >= limit);

    // Divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || restart || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + PW'(1);
        end
    end

endmodule

// File: rtl/wdt2_stage_ctr.sv
// Stage counter: one down-counter shared by both stages, with the stage
// tracked separately. Each stage lasts its preload in ticks (0 acts as 1).
// Emits a one-cycle expiry strobe per stage. Synchronous active-low reset.
module wdt2_stage_ctr
    import wdt2_pkg::*;
#(
    parameter int unsigned       CNT_W           = 20,
    parameter logic [CNT_W-1:0]  DEFAULT_PRELOAD = CNT_W'(30 << 9)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    input  logic             periodic,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    output logic [CNT_W-1:0] count,
    output stage_t           stage,
    output logic             expire1,
    output logic             expire2
);

    logic step_end;

    // A stage ends on a tick that finds the count at 1 or 0.
    assign step_end = run && tick && !restart && (stage != ST_DONE)
                      && (count <= CNT_W'(1));
    assign expire1  = step_end && (stage == ST_FIRST);
    assign expire2  = step_end && (stage == ST_SECOND);

    // Count and stage update: restart first, then tick-driven stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= ST_FIRST;
            count <= DEFAULT_PRELOAD;
        end else if (restart) begin
            stage <= ST_FIRST;
            count <= pre1;
        end else if (expire1) begin
            stage <= ST_SECOND;
            count <= pre2;
        end else if (expire2) begin
            if (periodic) begin
                stage <= ST_FIRST;
                count <= pre1;
            end else begin
                stage <= ST_DONE;
                count <= '0;
            end
        end else if (run && tick && (stage != ST_DONE)) begin
            count <= count - CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdt2_top.sv
// Two-stage lockable watchdog: register bus decode, key-guarded preload and
// restart writes, lock/enable control, interrupt shaping, reset request and
// a sticky timeout flag on its own power-on reset. Assumes one access per
// cycle, combinational read data, synchronous active-low resets.
module wdt2_top
    import wdt2_pkg::*;
#(
    parameter int unsigned      ADDR_W          = 5,
    parameter int unsigned      DATA_W          = 32,
    parameter int unsigned      CNT_W           = 20,
    parameter int unsigned      SLOW_SHIFT      = 15,
    parameter int unsigned      FAST_SHIFT      = 5,
    parameter logic [CNT_W-1:0] DEFAULT_PRELOAD = CNT_W'(30 << 9)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    localparam logic [ADDR_W-1:0] A_PRE1   = ADDR_W'(OFS_PRE1);
    localparam logic [ADDR_W-1:0] A_PRE2   = ADDR_W'(OFS_PRE2);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [DATA_W-1:0] KEY1     = DATA_W'(KEY_FIRST);
    localparam logic [DATA_W-1:0] KEY2     = DATA_W'(KEY_SECOND);

    // Address decode and access strobes
    logic wr_acc;
    logic hit_pre1, hit_pre2, hit_stat, hit_rld, hit_cfg, hit_ctrl, hit_cnt;
    logic granted;
    logic prot_wr;
    logic restart;
    logic sticky_clr;

    // State
    logic [CNT_W-1:0] pre1_q, pre2_q;
    wdt_cfg_t         cfg_q;
    wdt_ctrl_t        ctrl_q;
    logic             stat_q;
    logic             sticky_q;
    logic             rst_req_q;
    logic             pulse_q;

    // Timer datapath
    logic             tick;
    logic [CNT_W-1:0] count;
    stage_t           stage;
    logic             expire1, expire2;

    assign wr_acc   = bus_sel && bus_write;
    assign hit_pre1 = (bus_addr == A_PRE1);
    assign hit_pre2 = (bus_addr == A_PRE2);
    assign hit_stat = (bus_addr == A_STAT);
    assign hit_rld  = (bus_addr == A_RELOAD);
    assign hit_cfg  = (bus_addr == A_CFG);
    assign hit_ctrl = (bus_addr == A_CTRL);
    assign hit_cnt  = (bus_addr == A_COUNT);

    wdt2_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (bus_sel),
        .wr        (bus_write),
        .at_reload (hit_rld),
        .key1_hit  (bus_wdata == KEY1),
        .key2_hit  (bus_wdata == KEY2),
        .granted   (granted)
    );

    assign prot_wr    = wr_acc && granted && (hit_pre1 || hit_pre2 || hit_rld);
    assign restart    = prot_wr && hit_rld && bus_wdata[RLD_RESTART_BIT];
    assign sticky_clr = prot_wr && hit_rld && bus_wdata[RLD_FLAG_BIT];

    wdt2_prescaler #(
        .SLOW_SHIFT (SLOW_SHIFT),
        .FAST_SHIFT (FAST_SHIFT)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.enable),
        .restart (restart),
        .fast    (cfg_q.fast),
        .tick    (tick)
    );

    wdt2_stage_ctr #(
        .CNT_W           (CNT_W),
        .DEFAULT_PRELOAD (DEFAULT_PRELOAD)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_q.enable),
        .tick     (tick),
        .restart  (restart),
        .periodic (ctrl_q.periodic),
        .pre1     (pre1_q),
        .pre2     (pre2_q),
        .count    (count),
        .stage    (stage),
        .expire1  (expire1),
        .expire2  (expire2)
    );

    // Preload registers, written only through a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre1_q <= DEFAULT_PRELOAD;
            pre2_q <= DEFAULT_PRELOAD;
        end else begin
            if (prot_wr && hit_pre1) pre1_q <= bus_wdata[CNT_W-1:0];
            if (prot_wr && hit_pre2) pre2_q <= bus_wdata[CNT_W-1:0];
        end
    end

    // Configuration register, freely writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_acc && hit_cfg) begin
            cfg_q.rst_en   <= bus_wdata[CFG_RSTEN_BIT];
            cfg_q.fast     <= bus_wdata[CFG_FAST_BIT];
            cfg_q.irq_mode <= irq_mode_t'(bus_wdata[1:0]);
        end
    end

    // Control register, frozen once the lock bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_acc && hit_ctrl && !ctrl_q.locked) begin
            ctrl_q <= wdt_ctrl_t'(bus_wdata[2:0]);
        end
    end

    // Stage-1 status bit: set on expiry, write-one-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (expire1) begin
            stat_q <= 1'b1;
        end else if (wr_acc && hit_stat && bus_wdata[0]) begin
            stat_q <= 1'b0;
        end
    end

    // One-cycle pulse that follows each stage-1 expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= expire1;
        end
    end

    // Sticky timeout flag on the power-on reset only.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            sticky_q <= 1'b0;
        end else if (expire2 && !ctrl_q.periodic) begin
            sticky_q <= 1'b1;
        end else if (sticky_clr) begin
            sticky_q <= 1'b0;
        end
    end

    // Reset request: held from a watchdog expiry until restart or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else if (expire2 && !ctrl_q.periodic && cfg_q.rst_en) begin
            rst_req_q <= 1'b1;
        end else if (restart) begin
            rst_req_q <= 1'b0;
        end
    end

    // Interrupt shaping by the selected type.
    always_comb begin
        case (cfg_q.irq_mode)
            IRQ_LEVEL: irq = stat_q;
            IRQ_PULSE: irq = pulse_q;
            default:   irq = 1'b0;
        endcase
    end

    assign rst_req = rst_req_q;

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (hit_pre1) begin
            bus_rdata[CNT_W-1:0] = pre1_q;
        end else if (hit_pre2) begin
            bus_rdata[CNT_W-1:0] = pre2_q;
        end else if (hit_stat) begin
            bus_rdata[0] = stat_q;
        end else if (hit_rld) begin
            bus_rdata[RLD_FLAG_BIT] = sticky_q;
        end else if (hit_cfg) begin
            bus_rdata[CFG_RSTEN_BIT] = cfg_q.rst_en;
            bus_rdata[CFG_FAST_BIT]  = cfg_q.fast;
            bus_rdata[1:0]           = cfg_q.irq_mode;
        end else if (hit_ctrl) begin
            bus_rdata[2:0] = ctrl_q;
        end else if (hit_cnt) begin
            bus_rdata[CNT_W-1:0]     = count;
            bus_rdata[CNT_SECOND_BIT] = (stage == ST_SECOND);
            bus_rdata[CNT_DONE_BIT]   = (stage == ST_DONE);
        end
    end

endmodule

// File: rtl/wdt2_checker.sv
// Checker: temporal properties of the two-stage watchdog, attached to the
// top module by bind. Observes internal strobes and state read-only.
module wdt2_checker #(
    parameter int unsigned CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por_n,
    input logic             bus_sel,
    input logic             granted,
    input logic [2:0]       ctrl,
    input logic [CNT_W-1:0] count,
    input logic             restart,
    input logic             tick,
    input logic             in_second,
    input logic             rst_req,
    input logic             rst_en,
    input logic             sticky,
    input logic             sticky_clr,
    input logic             expire2
);

    // R2: a grant never survives the access that uses it.
    assert_grant_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && bus_sel) |=> !granted);

    // R9: a locked control register does not change.
    assert_lock_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[0] |=> $stable(ctrl));

    // R8: with enable clear and no restart the count holds.
    assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[1] && !restart) |=> $stable(count));

    // R4: stage 2 is entered only on a prescaler tick.
    assert_stage2_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_second) |-> $past(tick));

    // R6: the reset request rises only with reset-on-expiry enabled.
    assert_req_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(rst_en));

    // R10: a periodic-mode expiry raises no reset request.
    assert_periodic_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (expire2 && ctrl[2] && !rst_req) |=> !rst_req);

    // R7: the flag stays set unless cleared by a granted write.
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        (sticky && !sticky_clr) |=> sticky);

endmodule

bind wdt2_top wdt2_checker #(.CNT_W(CNT_W)) u_wdt2_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_n      (por_n),
    .bus_sel    (bus_sel),
    .granted    (granted),
    .ctrl       (ctrl_q),
    .count      (count),
    .restart    (restart),
    .tick       (tick),
    .in_second  (stage == wdt2_pkg::ST_SECOND),
    .rst_req    (rst_req),
    .rst_en     (cfg_q.rst_en),
    .sticky     (sticky_q),
    .sticky_clr (sticky_clr),
    .expire2    (expire2)
);

// File: tb/wdt2_top_bench.sv
`timescale 1ns/1ps
// Bench: a register-access vector table walked by one loop, then directed
// timing, lock, flag and reset tests. Inputs change on the falling edge.
module wdt2_top_bench;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned CNT_W  = 20;
    localparam int unsigned SLOW_SH = 6;
    localparam int unsigned FAST_SH = 2;
    localparam int unsigned DEFPRE  = 100;

    localparam logic [1:0] K_WR = 2'd0;
    localparam logic [1:0] K_RD = 2'd1;
    localparam logic [1:0] K_UW = 2'd2;

    localparam logic [4:0] A_P1 = 5'h00, A_P2 = 5'h04, A_ST = 5'h08,
                           A_RL = 5'h0C, A_CF = 5'h10, A_CT = 5'h14,
                           A_CN = 5'h18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              por_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;
    logic              rst_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    wdt2_top #(
        .ADDR_W          (ADDR_W),
        .DATA_W          (DATA_W),
        .CNT_W           (CNT_W),
        .SLOW_SHIFT      (SLOW_SH),
        .FAST_SHIFT      (FAST_SH),
        .DEFAULT_PRELOAD (CNT_W'(DEFPRE))
    ) u_wdt2_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .bus_sel   (bus_sel),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    // Vector: {kind, offset, data}; for reads data is the expected value.
    localparam int NV = 21;
    localparam logic [38:0] VEC [NV] = '{
        {K_RD, A_P1, 32'd100},      // R11 preload default
        {K_RD, A_CN, 32'd100},      // R11 count default, stage 1
        {K_RD, A_CF, 32'h0},        // R11 config zero
        {K_RD, A_CT, 32'h0},        // R11 control zero
        {K_WR, A_P1, 32'd5},        // R1 write without key
        {K_RD, A_P1, 32'd100},      // R1 ignored
        {K_UW, A_P1, 32'd5},        // R1 keyed write
        {K_RD, A_P1, 32'd5},        // R1 took effect
        {K_WR, A_P2, 32'd7},        // R2 grant already spent
        {K_RD, A_P2, 32'd100},      // R2 ignored
        {K_WR, A_RL, 32'h80},       // R2 first key
        {K_RD, A_ST, 32'h0},        // R2 intervening read
        {K_WR, A_RL, 32'h86},       // R2 second key, pair broken
        {K_WR, A_P2, 32'd9},        // R2 no grant
        {K_RD, A_P2, 32'd100},      // R2 ignored
        {K_UW, A_P2, 32'd3},        // R1 keyed write
        {K_RD, A_P2, 32'd3},        // R1 took effect
        {K_UW, A_RL, 32'h100},      // R3 restart while disabled
        {K_RD, A_CN, 32'd5},        // R3 count from stage-1 preload
        {K_WR, A_CF, 32'h27},       // R5 config write
        {K_RD, A_CF, 32'h27}        // R5 R6 config readback
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic do_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic do_keyed(input logic [4:0] a, input logic [31:0] d);
        do_write(A_RL, 32'h80);
        do_write(A_RL, 32'h86);
        do_write(a, d);
    endtask

    task automatic read_check(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        do_read(a, v);
        check(tag, v, exp);
    endtask

    task automatic block_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        check("R11 irq after reset", {31'b0, irq}, 32'd0);
        check("R11 rst_req after reset", {31'b0, rst_req}, 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k;
            logic [4:0]  a;
            logic [31:0] d;
            logic [31:0] v;
            {k, a, d} = VEC[i];
            case (k)
                K_WR: do_write(a, d);
                K_UW: do_keyed(a, d);
                default: begin
                    do_read(a, v);
                    check($sformatf("vector %0d", i), v, d);
                end
            endcase
        end

        // R8: disabled count holds
        repeat (50) @(negedge clk);
        read_check("R8 count held while disabled", A_CN, 32'd5);

        // R4 R5 R6: fast ticks, level irq, reset request on
        do_write(A_CF, 32'h24);
        do_write(A_CT, 32'h02);
        do_keyed(A_RL, 32'h100);
        repeat (19) @(negedge clk);
        check("R4 irq before stage-1 end", {31'b0, irq}, 32'd0);
        @(negedge clk);
        check("R4 R5 irq at stage-1 end", {31'b0, irq}, 32'd1);
        repeat (11) @(negedge clk);
        check("R4 rst_req before stage-2 end", {31'b0, rst_req}, 32'd0);
        @(negedge clk);
        check("R6 rst_req at stage-2 end", {31'b0, rst_req}, 32'd1);
        read_check("R6 timeout flag", A_RL, 32'h200);
        read_check("R6 counter stopped", A_CN, 32'h0200_0000);
        do_write(A_ST, 32'h1);
        check("R5 irq cleared by status write", {31'b0, irq}, 32'd0);

        // R7 R11: flag survives block reset, then cleared by keyed write
        block_reset();
        check("R11 rst_req cleared by reset", {31'b0, rst_req}, 32'd0);
        read_check("R7 flag after block reset", A_RL, 32'h200);
        read_check("R11 preload after block reset", A_P1, DEFPRE);
        do_keyed(A_RL, 32'h200);
        read_check("R7 flag cleared by keyed write", A_RL, 32'h0);

        // R10 R5: periodic function, pulse interrupt
        do_keyed(A_P1, 32'd2);
        do_keyed(A_P2, 32'd2);
        do_write(A_CF, 32'h25);
        do_write(A_CT, 32'h06);
        do_keyed(A_RL, 32'h100);
        repeat (7) @(negedge clk);
        check("R5 no pulse before stage-1 end", {31'b0, irq}, 32'd0);
        @(negedge clk);
        check("R5 pulse at stage-1 end", {31'b0, irq}, 32'd1);
        @(negedge clk);
        check("R5 pulse lasts one cycle", {31'b0, irq}, 32'd0);
        repeat (8) @(negedge clk);
        check("R10 no reset request in periodic mode", {31'b0, rst_req}, 32'd0);
        repeat (7) @(negedge clk);
        check("R10 stage 1 restarted, pulse again", {31'b0, irq}, 32'd1);
        read_check("R10 no timeout flag", A_RL, 32'h0);

        // R9: lock freezes control until block reset
        do_write(A_CT, 32'h03);
        read_check("R9 lock set", A_CT, 32'h3);
        do_write(A_CT, 32'h00);
        read_check("R9 clear ignored while locked", A_CT, 32'h3);
        block_reset();
        read_check("R9 block reset unlocks", A_CT, 32'h0);

        // R4 R5: slow ticks, level irq; then irq type none
        do_keyed(A_P1, 32'd2);
        do_write(A_CT, 32'h02);
        do_keyed(A_RL, 32'h100);
        repeat (127) @(negedge clk);
        check("R4 slow irq before stage-1 end", {31'b0, irq}, 32'd0);
        @(negedge clk);
        check("R4 slow irq at stage-1 end", {31'b0, irq}, 32'd1);
        do_write(A_CF, 32'h03);
        check("R5 irq type none masks irq", {31'b0, irq}, 32'd0);
        read_check("R5 status still set", A_ST, 32'h1);

        // R6: expiry with reset request disabled
        repeat (6600) @(negedge clk);
        check("R6 no rst_req when disabled", {31'b0, rst_req}, 32'd0);
        read_check("R6 flag set on expiry", A_RL, 32'h200);
        read_check("R6 counter stopped", A_CN, 32'h0200_0000);

        // R7: power-on reset clears the flag
        @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        read_check("R7 power-on reset clears flag", A_RL, 32'h0);

        summary();
        $finish;
    end

endmodule